// File: doc/BRIEF.md
# Light Sensor Conversion and Interrupt Controller

This block is the digital core of an ambient and infrared light sensor. The front end hands it two pulse inputs, one per channel. A host reads and writes a small byte-wide register bank to choose an operating mode and a resolution. The block then runs integration windows, counts the pulses of the selected channel over each window, and stores the count in two read-only data bytes. A lower threshold can be programmed, and a visible-light result at or under it raises a sticky interrupt.

A three-state sequencer drives the work. ST_IDLE waits for a mode write. ST_INTEG counts cycles and pulses until the window is complete. ST_STORE lasts one cycle, latches the result and evaluates the interrupt. These are the transitions:
- A mode write with a runnable code moves any state to ST_INTEG. A mode write with the off code or a reserved code moves any state to ST_IDLE.
- ST_INTEG moves to ST_STORE on the last cycle of the window.
- ST_STORE moves back to ST_INTEG in a continuous mode. In a single-shot mode it moves to ST_IDLE and clears the mode field.
- ST_IDLE otherwise stays where it is.

The resolution field sets the window length and the result width together. A window of 2^w cycles gives a w-bit result, and the pulse count saturates at 2^w-1.

Top module: `lsc_top`

## Requirements
- R1: After reset, every register at addresses 0x00 to 0x05 reads 0x00, irq_flag is 0 and irq_n is 1. The threshold bytes at 0x04 (low) and 0x05 (high) read back what was written.
- R2: Register 0x01 keeps range in bits 1:0 and resolution in bits 3:2. Bits 7:4 always read zero.
- R3: Resolution code c (00, 01, 10, 11) gives a window of L = 2^(16-4c) cycles. A new result is readable after the (L+1)th rising edge that follows the mode-write edge, and not after the Lth.
- R4: The result is right-aligned with width 16-4c. Bits above that width read zero. A channel held active for the whole window yields 2^(16-4c)-1, so the count saturates and does not wrap.
- R5: Address 0x02 returns result bits 7:0 and 0x03 returns bits 15:8. Host writes to these two addresses are ignored.
- R6: Mode bits 7:5 of register 0x00 select the mode. Code 001 is single-shot visible and 010 is single-shot infrared. After one result, a single-shot mode reads back as 000 and no further result is stored.
- R7: Code 101 (continuous visible) and code 110 (continuous infrared) store a result every L+1 cycles until the mode is rewritten.
- R8: Codes 011, 100 and 111 are stored and read back, but they start no conversion. The data registers keep their value.
- R9: Any write to register 0x00 aborts a window in progress and clears the pulse count. A rewrite with a runnable code restarts the window from zero.
- R10: A visible result less than or equal to the 16-bit threshold sets irq_flag. A visible result above the threshold leaves irq_flag clear.
- R11: Infrared modes count ir_pulse, not vis_pulse, and update the data registers. They never set irq_flag.
- R12: irq_flag is sticky and irq_n is its active-low copy. A read of 0x00 (reg_rd with address 0) clears the flag. If a threshold hit lands on the same edge as that read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only address 0 has a read side effect) |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| vis_pulse | input | 1 | Visible-channel pulse, sampled every clock |
| ir_pulse | input | 1 | Infrared-channel pulse, sampled every clock |
| irq_n | output | 1 | Active-low interrupt |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two events can fall on the same clock edge: the ST_STORE cycle of a visible conversion whose result passes the threshold, and a host read of register 0x00 that clears the flag. The bench provokes this by counting edges from the mode write and placing the read strobe on exactly the (L+1)th edge. The read returns the mode byte of the cycle before the clear, and irq_flag must still be 1 afterwards. A second read must then clear it.

// File: rtl/lsc_pkg.sv
`timescale 1ns/100ps
package lsc_pkg;
    localparam int CNT_W    = 16;
    localparam int RES_STEP = 4;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int MODE_W   = 3;

    localparam logic [MODE_W-1:0] MD_OFF     = 3'b000;
    localparam logic [MODE_W-1:0] MD_VIS_ONE = 3'b001;
    localparam logic [MODE_W-1:0] MD_IR_ONE  = 3'b010;
    localparam logic [MODE_W-1:0] MD_VIS_RUN = 3'b101;
    localparam logic [MODE_W-1:0] MD_IR_RUN  = 3'b110;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DLO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DHI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TLO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_THI  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_STORE = 2'd2
    } seq_state_e;

    function automatic logic md_starts(input logic [MODE_W-1:0] m);
        return (m == MD_VIS_ONE) || (m == MD_IR_ONE) ||
               (m == MD_VIS_RUN) || (m == MD_IR_RUN);
    endfunction

    function automatic logic md_is_ir(input logic [MODE_W-1:0] m);
        return (m == MD_IR_ONE) || (m == MD_IR_RUN);
    endfunction

    function automatic logic md_is_run(input logic [MODE_W-1:0] m);
        return (m == MD_VIS_RUN) || (m == MD_IR_RUN);
    endfunction

    // 2^w - 1 with w = CNT_W - RES_STEP*code: both the saturation limit
    // and the index of the last window cycle.
    function automatic logic [CNT_W-1:0] res_mask(input logic [1:0] r);
        logic [CNT_W:0] one;
        logic [CNT_W:0] t;
        int w;
        one = {{CNT_W{1'b0}}, 1'b1};
        w   = CNT_W - RES_STEP * int'(r);
        t   = (one << w) - one;
        return t[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/lsc_pulse_ctr.sv
`timescale 1ns/100ps
module lsc_pulse_ctr
    import lsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             pulse,
    input  logic [1:0]       res,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] lim;
    assign lim = res_mask(res);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && pulse && (count < lim)) begin
            count <= count + CNT_W'(1);
        end
    end

    // R4: a pulse at the width limit does not wrap the count
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && pulse && (count >= lim)) |=> $stable(count));
endmodule

// File: rtl/lsc_seq.sv
`timescale 1ns/100ps
module lsc_seq
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_new,
    input  logic [MODE_W-1:0] mode_cur,
    input  logic [1:0]        res,
    output logic              ctr_clr,
    output logic              ctr_en,
    output logic              chan_ir,
    output logic              store,
    output logic              store_vis,
    output logic              mode_clr
);
    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] last_cyc;

    assign last_cyc = res_mask(res);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cyc_q <= '0;
        else if (mode_wr || st_q != ST_INTEG) cyc_q <= '0;
        else                                 cyc_q <= cyc_q + CNT_W'(1);
    end

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d = md_starts(mode_new) ? ST_INTEG : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_INTEG: if (cyc_q >= last_cyc) st_d = ST_STORE;
                ST_STORE: st_d = md_is_run(mode_cur) ? ST_INTEG : ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctr_en  = 1'b0;
        store   = 1'b0;
        ctr_clr = mode_wr;
        unique case (st_q)
            ST_IDLE:  ;
            ST_INTEG: ctr_en = 1'b1;
            ST_STORE: begin
                store   = 1'b1;
                ctr_clr = 1'b1;
            end
            default:  ;
        endcase
        chan_ir   = md_is_ir(mode_cur);
        store_vis = store && !md_is_ir(mode_cur);
        mode_clr  = store && !mode_wr && !md_is_run(mode_cur);
    end

    // R3: the window does not end before its last cycle
    p_integ_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_INTEG && !mode_wr && cyc_q < last_cyc) |=> (st_q == ST_INTEG));
    // R6: single-shot returns to idle
    p_oneshot_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STORE && !mode_wr && !md_is_run(mode_cur)) |=> (st_q == ST_IDLE));
    // R7: continuous restarts a fresh window
    p_cont_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STORE && !mode_wr && md_is_run(mode_cur)) |=> (st_q == ST_INTEG && cyc_q == '0));
    // R8: off or reserved codes park the sequencer
    p_reserved_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !md_starts(mode_new)) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/lsc_regs.sv
`timescale 1ns/100ps
module lsc_regs
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              mode_clr,
    input  logic              store,
    input  logic              store_vis,
    input  logic [CNT_W-1:0]  result,
    output logic [MODE_W-1:0] mode_q,
    output logic [1:0]        res_q,
    output logic              mode_wr,
    output logic              flag
);
    logic [1:0]       rng_q;
    logic [CNT_W-1:0] data_q;
    logic [CNT_W-1:0] thr_q;
    logic             rd_clr;
    logic             hit;

    assign mode_wr = wr && (addr == A_CTRL);
    assign rd_clr  = rd && (addr == A_CTRL);
    assign hit     = store_vis && (result <= thr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode_q <= MD_OFF;
        else if (mode_wr)  mode_q <= wdata[BYTE_W-1 -: MODE_W];
        else if (mode_clr) mode_q <= MD_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q <= '0;
            res_q <= '0;
            thr_q <= '0;
        end else if (wr) begin
            if (addr == A_CFG) begin
                rng_q <= wdata[1:0];
                res_q <= wdata[3:2];
            end
            if (addr == A_TLO) thr_q[BYTE_W-1:0]     <= wdata;
            if (addr == A_THI) thr_q[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     data_q <= '0;
        else if (store) data_q <= result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hit)    flag <= 1'b1;
        else if (rd_clr) flag <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = {mode_q, {(BYTE_W-MODE_W){1'b0}}};
            A_CFG:   rdata = {{(BYTE_W-4){1'b0}}, res_q, rng_q};
            A_DLO:   rdata = data_q[BYTE_W-1:0];
            A_DHI:   rdata = data_q[CNT_W-1:BYTE_W];
            A_TLO:   rdata = thr_q[BYTE_W-1:0];
            A_THI:   rdata = thr_q[CNT_W-1:BYTE_W];
            default: rdata = '0;
        endcase
    end

    // R5: data bytes change only on a stored result
    p_data_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> $stable(data_q));
    // R10: a visible hit raises the flag
    p_vis_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R11: infrared results never raise the flag
    p_ir_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !store_vis && !flag) |=> !flag);
    // R12: the flag holds until a read of the control register
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_clr) |=> flag);
endmodule

// File: rtl/lsc_top.sv
`timescale 1ns/100ps
module lsc_top
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              vis_pulse,
    input  logic              ir_pulse,
    output logic              irq_n,
    output logic              irq_flag
);
    logic [MODE_W-1:0] mode_q;
    logic [1:0]        res_q;
    logic              mode_wr;
    logic              ctr_clr, ctr_en, chan_ir, store, store_vis, mode_clr;
    logic              pulse_sel;
    logic [CNT_W-1:0]  count;

    assign pulse_sel = chan_ir ? ir_pulse : vis_pulse;

    lsc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .mode_clr  (mode_clr),
        .store     (store),
        .store_vis (store_vis),
        .result    (count),
        .mode_q    (mode_q),
        .res_q     (res_q),
        .mode_wr   (mode_wr),
        .flag      (irq_flag)
    );

    lsc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_new  (reg_wdata[BYTE_W-1 -: MODE_W]),
        .mode_cur  (mode_q),
        .res       (res_q),
        .ctr_clr   (ctr_clr),
        .ctr_en    (ctr_en),
        .chan_ir   (chan_ir),
        .store     (store),
        .store_vis (store_vis),
        .mode_clr  (mode_clr)
    );

    lsc_pulse_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .en    (ctr_en),
        .pulse (pulse_sel),
        .res   (res_q),
        .count (count)
    );

    assign irq_n = ~irq_flag;

    // R9: a control write leaves the pulse count at zero
    p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL) |=> (count == '0));
endmodule

// File: tb/lsc_top_bench.sv
`timescale 1ns/100ps
module lsc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       vis_lvl = 1'b0, tog_en = 1'b0, tog_sig = 1'b0, ir_pulse = 1'b0;
    logic       vis_pulse;
    logic       irq_n, irq_flag;
    int         n_chk = 0, n_bad = 0;
    logic       done = 1'b0;

    assign vis_pulse = tog_en ? tog_sig : vis_lvl;

    always #2 clk = ~clk;
    always @(negedge clk) tog_sig <= ~tog_sig;

    lsc_top u_lsc_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vis_pulse(vis_pulse), .ir_pulse(ir_pulse),
        .irq_n(irq_n), .irq_flag(irq_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #0.1 d = int'(reg_rdata);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output int d);
        reg_addr = a;
        #0.1 d = int'(reg_rdata);
    endtask

    task automatic get_res(output int v);
        int lo, hi;
        peek(3'd2, lo);
        peek(3'd3, hi);
        v = hi * 256 + lo;
    endtask

    // call right after wr_reg of the mode; checks the stale and the new result
    task automatic conv_check(input string tag, input int len, input int old_v, input int new_v);
        int v;
        repeat (len) @(posedge clk);
        @(negedge clk);
        get_res(v);
        chk({tag, " stale"}, v, old_v);
        @(posedge clk);
        @(negedge clk);
        get_res(v);
        chk(tag, v, new_v);
    endtask

    task automatic t_reset;
        int v;
        @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            peek(3'(a), v);
            chk("R1 reset reg", v, 0);
        end
        chk("R1 reset flag", int'(irq_flag), 0);
        chk("R1 reset irq_n", int'(irq_n), 1);
    endtask

    task automatic t_cfg;
        int v;
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd1, v);   chk("R2 cfg upper bits zero", v, 8'h0F);
        wr_reg(3'd2, 8'h55);
        wr_reg(3'd3, 8'hAA);
        rd_reg(3'd2, v);   chk("R5 data low not writable", v, 0);
        rd_reg(3'd3, v);   chk("R5 data high not writable", v, 0);
        wr_reg(3'd4, 8'h34);
        wr_reg(3'd5, 8'h12);
        rd_reg(3'd4, v);   chk("R1 thr low readback", v, 8'h34);
        rd_reg(3'd5, v);   chk("R1 thr high readback", v, 8'h12);
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd5, 8'h00);
    endtask

    task automatic t_single_4bit;
        int v;
        wr_reg(3'd1, 8'h0C);
        vis_lvl = 1'b1;
        wr_reg(3'd0, 8'h20);
        conv_check("R3 R4 4-bit saturated", 16, 0, 15);
        rd_reg(3'd0, v);   chk("R6 single-shot mode cleared", v, 0);
        chk("R10 above threshold no flag", int'(irq_flag), 0);
        vis_lvl = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        get_res(v);        chk("R6 no further conversion", v, 15);
    endtask

    task automatic t_widths;
        wr_reg(3'd1, 8'h08);
        tog_en = 1'b1;
        wr_reg(3'd0, 8'h20);
        conv_check("R3 8-bit window", 256, 15, 128);
        tog_en = 1'b0; vis_lvl = 1'b1;
        wr_reg(3'd0, 8'h20);
        conv_check("R4 8-bit saturated", 256, 128, 255);
        wr_reg(3'd1, 8'h04);
        tog_en = 1'b1;
        wr_reg(3'd0, 8'h20);
        conv_check("R3 R5 12-bit window", 4096, 255, 2048);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd0, 8'h20);
        conv_check("R3 R5 16-bit window", 65536, 2048, 32768);
        tog_en = 1'b0;
    endtask

    task automatic t_continuous;
        int v;
        wr_reg(3'd1, 8'h0C);
        vis_lvl = 1'b1;
        wr_reg(3'd0, 8'hA0);
        conv_check("R7 first continuous result", 16, 32768, 15);
        vis_lvl = 1'b0;
        conv_check("R7 second continuous result", 16, 15, 0);
        chk("R10 equal threshold sets flag", int'(irq_flag), 1);
        chk("R12 irq_n low", int'(irq_n), 0);
        wr_reg(3'd0, 8'h00);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R12 flag sticky", int'(irq_flag), 1);
        rd_reg(3'd0, v);
        chk("R12 read clears flag", int'(irq_flag), 0);
        chk("R12 irq_n released", int'(irq_n), 1);
    endtask

    task automatic t_threshold;
        int v;
        wr_reg(3'd4, 8'd10);
        tog_en = 1'b1;
        wr_reg(3'd0, 8'h20);
        conv_check("R10 8 vs thr 10 result", 16, 0, 8);
        chk("R10 below threshold sets flag", int'(irq_flag), 1);
        rd_reg(3'd0, v);
        wr_reg(3'd4, 8'd7);
        wr_reg(3'd0, 8'h20);
        conv_check("R10 8 vs thr 7 result", 16, 8, 8);
        chk("R10 above threshold no flag", int'(irq_flag), 0);
        tog_en = 1'b0;
    endtask

    task automatic t_infrared;
        wr_reg(3'd4, 8'hFF);
        wr_reg(3'd5, 8'hFF);
        vis_lvl = 1'b0; ir_pulse = 1'b1;
        wr_reg(3'd0, 8'h40);
        conv_check("R11 infrared counts ir_pulse", 16, 8, 15);
        chk("R11 infrared no flag", int'(irq_flag), 0);
        ir_pulse = 1'b0;
        wr_reg(3'd0, 8'hC0);
        conv_check("R7 R11 continuous infrared", 16, 15, 0);
        chk("R11 infrared zero no flag", int'(irq_flag), 0);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_reserved;
        int v;
        logic [7:0] codes [3] = '{8'h60, 8'h80, 8'hE0};
        vis_lvl = 1'b1; ir_pulse = 1'b1;
        for (int i = 0; i < 3; i++) begin
            wr_reg(3'd0, codes[i]);
            repeat (40) @(posedge clk);
            @(negedge clk);
            get_res(v);       chk("R8 reserved starts nothing", v, 0);
            rd_reg(3'd0, v);  chk("R8 reserved readback", v, int'(codes[i]));
        end
        wr_reg(3'd0, 8'h00);
        ir_pulse = 1'b0;
    endtask

    task automatic t_abort;
        vis_lvl = 1'b1;
        wr_reg(3'd0, 8'h20);
        conv_check("R9 setup result", 16, 0, 15);
        wr_reg(3'd0, 8'h20);
        repeat (8) @(posedge clk);
        @(negedge clk);
        vis_lvl = 1'b0;
        wr_reg(3'd0, 8'h20);
        conv_check("R9 restart with cleared count", 16, 15, 0);
    endtask

    task automatic t_collision;
        int v;
        rd_reg(3'd0, v);
        chk("R12 flag cleared before race", int'(irq_flag), 0);
        vis_lvl = 1'b1;
        wr_reg(3'd0, 8'h20);
        repeat (16) @(posedge clk);
        rd_reg(3'd0, v);
        chk("R12 race read value", v, 8'h20);
        chk("R12 set wins over clear", int'(irq_flag), 1);
        rd_reg(3'd0, v);
        chk("R12 second read clears", int'(irq_flag), 0);
        vis_lvl = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_cfg;
        t_single_4bit;
        t_widths;
        t_continuous;
        t_threshold;
        t_infrared;
        t_reserved;
        t_abort;
        t_collision;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule